// File: doc/BRIEF.md
# Serial Bit-Rate Auto-Detector

This block works out the bit period of an asynchronous serial line whose rate is not known in advance. It watches one serial input, measures in clock cycles how long the line stays at one level between two consecutive level changes, and keeps the shortest such run as its estimate of one bit time. A run shorter than the estimate can show up long after detection starts, so the estimate moves downward each time a shorter run is measured. The sender has to include isolated bits (patterns such as 010 or 101) for the estimate to reach one bit time. A line that only ever carries paired runs such as 0011 yields twice the period.

The line first passes through a two-stage synchronizer. An edge detector then restarts a saturating run counter on each level change. A controller decides what each closed run means. The first, partial run after reset or clear is discarded. Runs shorter than `MIN_CYCLES` are discarded as glitches. Runs that saturate the counter are discarded as too long. A lock flag rises once `LOCK_EDGES` consecutive accepted runs have failed to lower the estimate, and it drops whenever the estimate changes.

The controller has four named states:
- `ST_IDLE`: no edge seen since reset or clear. The first edge moves it to `ST_SEARCH`.
- `ST_SEARCH`: a run is open but no estimate exists yet. The first accepted run sets the estimate and moves it to `ST_TRACK`.
- `ST_TRACK`: an estimate exists and the controller counts non-lowering runs. A shorter run replaces the estimate, stays in `ST_TRACK` and zeroes the count. The run that makes the count reach `LOCK_EDGES` moves it to `ST_LOCKED`.
- `ST_LOCKED`: a shorter run replaces the estimate and returns it to `ST_TRACK`.

Asserting `clear` moves any state to `ST_IDLE`.

Top module: `baud_rate_detector`

## Requirements
- R1: After reset, and in the cycle after a synchronous `clear`, `period_est` is all ones and `locked` is 0.
- R2: A run is the number of clock cycles the line holds one level between two consecutive edges. `period_est` equals the shortest accepted run so far. Longer runs never raise it.
- R3: When an accepted run is shorter than the current `period_est`, that run replaces the estimate. The replacement is visible three clock edges after the input change that closes the run.
- R4: The first run after reset or after `clear` is partial and is never used as an estimate.
- R5: A run shorter than `MIN_CYCLES` is ignored. A run of exactly `MIN_CYCLES` is accepted.
- R6: A run that reaches the counter maximum (2^`CNT_W`-1 cycles or more) is ignored.
- R7: `locked` goes to 1 after `LOCK_EDGES` consecutive accepted runs that do not lower the estimate, counted from the run that last set it. It does not go to 1 before that.
- R8: `locked` is 0 whenever `period_est` has just changed. A run that does not lower the estimate leaves `locked` as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous restart of detection |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| period_est | output | CNT_W | Shortest accepted run in clock cycles; all ones means no estimate |
| locked | output | 1 | Estimate has been stable for `LOCK_EDGES` runs |

## Verification
A repeated run length shows that a closed run is measured exactly. Equal-length runs followed by a single shorter run, and then a longer run, show that the estimate moves down and never up. A 3-cycle glitch next to a 4-cycle run shows the glitch threshold. Runs of 1100, 1023 and 1022 cycles on a 10-bit counter locate the saturation boundary. A train of equal runs, checked after 15 and after 16 repetitions, shows when lock is reached, and a shorter run after lock shows that lock drops again.

// File: rtl/baud_det_pkg.sv
package baud_det_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_TRACK  = 2'd2,
        ST_LOCKED = 2'd3
    } det_state_t;
endpackage

// File: rtl/baud_det_sync.sv
module baud_det_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic edge_seen
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            last_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_in};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign edge_seen = chain_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/baud_det_runcnt.sv
module baud_det_runcnt #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             edge_seen,
    output logic [CNT_W-1:0] run_len
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (edge_seen) begin
            cnt_q <= CNT_W'(1);
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign run_len = cnt_q;

    assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !edge_seen && !clear) |=> cnt_q == CNT_MAX);
    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && !clear) |=> cnt_q == CNT_W'(1));
endmodule

// File: rtl/baud_det_fsm.sv
module baud_det_fsm
    import baud_det_pkg::*;
#(
    parameter int CNT_W      = 20,
    parameter int MIN_CYCLES = 4,
    parameter int LOCK_EDGES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             edge_seen,
    input  logic [CNT_W-1:0] run_len,
    output logic [CNT_W-1:0] est_out,
    output logic             locked_out
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(MIN_CYCLES);
    localparam int               STK_W   = $clog2(LOCK_EDGES + 1);
    localparam logic [STK_W-1:0] STK_TOP = STK_W'(LOCK_EDGES - 1);

    det_state_t       state_q, state_d;
    logic [CNT_W-1:0] est_q;
    logic [STK_W-1:0] streak_q;
    logic             run_ok, run_lower;

    assign run_ok    = edge_seen && (run_len != CNT_MAX) && (run_len >= MIN_LEN);
    assign run_lower = run_ok && (run_len < est_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (edge_seen) state_d = ST_SEARCH;
            ST_SEARCH: if (run_ok) state_d = ST_TRACK;
            ST_TRACK:  if (run_ok && !run_lower && streak_q == STK_TOP) state_d = ST_LOCKED;
            ST_LOCKED: if (run_lower) state_d = ST_TRACK;
            default:   state_d = ST_IDLE;
        endcase
        if (clear) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            est_q    <= CNT_MAX;
            streak_q <= '0;
        end else if (clear) begin
            est_q    <= CNT_MAX;
            streak_q <= '0;
        end else if (state_q != ST_IDLE && run_ok) begin
            if (run_lower) begin
                est_q    <= run_len;
                streak_q <= '0;
            end else if (streak_q != STK_TOP + STK_W'(1)) begin
                streak_q <= streak_q + STK_W'(1);
            end
        end
    end

    always_comb begin
        est_out    = est_q;
        locked_out = (state_q == ST_LOCKED);
    end

    assert_no_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> est_q <= $past(est_q));
    assert_min_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        est_q != CNT_MAX |-> est_q >= MIN_LEN);
    assert_lock_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(est_q) |-> state_q != ST_LOCKED);
    assert_idle_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |-> est_q == CNT_MAX);
    assert_lock_has_est_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LOCKED |-> est_q != CNT_MAX);
endmodule

// File: rtl/baud_rate_detector.sv
module baud_rate_detector #(
    parameter int CNT_W       = 20,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_CYCLES  = 4,
    parameter int LOCK_EDGES  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             rx_in,
    output logic [CNT_W-1:0] period_est,
    output logic             locked
);
    logic             edge_seen;
    logic [CNT_W-1:0] run_len;

    baud_det_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (rx_in),
        .edge_seen (edge_seen)
    );

    baud_det_runcnt #(.CNT_W(CNT_W)) u_runcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .edge_seen (edge_seen),
        .run_len   (run_len)
    );

    baud_det_fsm #(
        .CNT_W      (CNT_W),
        .MIN_CYCLES (MIN_CYCLES),
        .LOCK_EDGES (LOCK_EDGES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .edge_seen  (edge_seen),
        .run_len    (run_len),
        .est_out    (period_est),
        .locked_out (locked)
    );
endmodule

// File: tb/baud_rate_detector_bench.sv
module baud_rate_detector_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 10;
    localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clear = 1'b0;
    logic             rx_in = 1'b1;
    logic [CNT_W-1:0] period_est;
    logic             locked;
    int               n_run = 0;
    int               n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_rate_detector #(.CNT_W(CNT_W), .SYNC_STAGES(2), .MIN_CYCLES(4), .LOCK_EDGES(16))
        u_baud_rate_detector (
        .clk(clk), .rst_n(rst_n), .clear(clear), .rx_in(rx_in),
        .period_est(period_est), .locked(locked));

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_runs(input int n, input int len);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) rx_in = ~rx_in;
            repeat (len - 1) @(negedge clk);
        end
    endtask

    task automatic do_clear();
        @(negedge clk) clear = 1'b1;
        @(negedge clk) clear = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 est", int'(period_est), int'(ALL1));
        chk("R1 lock", int'(locked), 0);
    endtask

    task automatic t_partial();
        do_clear();
        repeat (3) @(negedge clk);
        send_runs(1, 25);
        send_runs(1, 30);
        chk("R4 partial ignored", int'(period_est), 25);
        chk("R4 lock", int'(locked), 0);
    endtask

    task automatic t_refine();
        do_clear();
        send_runs(1, 16);
        send_runs(3, 16);
        chk("R2 pairs", int'(period_est), 16);
        send_runs(1, 8);
        send_runs(1, 20);
        chk("R3 shorter", int'(period_est), 8);
        send_runs(1, 12);
        chk("R2 no raise", int'(period_est), 8);
    endtask

    task automatic t_glitch();
        do_clear();
        send_runs(2, 12);
        chk("R5 base", int'(period_est), 12);
        send_runs(1, 3);
        send_runs(1, 12);
        chk("R5 glitch", int'(period_est), 12);
        send_runs(1, 4);
        send_runs(1, 12);
        chk("R5 min ok", int'(period_est), 4);
    endtask

    task automatic t_overflow();
        do_clear();
        send_runs(1, 1100);
        send_runs(1, 1023);
        chk("R6 long", int'(period_est), int'(ALL1));
        send_runs(1, 1022);
        chk("R6 at max", int'(period_est), int'(ALL1));
        send_runs(1, 6);
        chk("R6 below max", int'(period_est), 1022);
    endtask

    task automatic t_lock();
        do_clear();
        send_runs(2, 10);
        chk("R7 est", int'(period_est), 10);
        send_runs(15, 10);
        chk("R7 early", int'(locked), 0);
        send_runs(1, 10);
        chk("R7 locked", int'(locked), 1);
        send_runs(1, 14);
        chk("R8 keep", int'(locked), 1);
        send_runs(1, 6);
        send_runs(1, 10);
        chk("R8 est", int'(period_est), 6);
        chk("R8 drop", int'(locked), 0);
    endtask

    task automatic t_clear();
        do_clear();
        chk("R1 clear est", int'(period_est), int'(ALL1));
        chk("R1 clear lock", int'(locked), 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_partial();
                t_refine();
                t_glitch();
                t_overflow();
                t_lock();
                t_clear();
            end
            begin
                repeat (100000) @(negedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule